// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block drives one chip-enable space of external asynchronous memory, for example a parallel NOR flash. A client presents a request with address, write data and direction. The controller runs the transfer on the memory pins in three timed phases: an address setup phase, a strobe phase during which output-enable (reads) or write-enable (writes) is active, and a hold phase. Read data comes back on `rspData` together with a one-cycle `rspDone` pulse; writes also finish with `rspDone`.

Phase lengths come from a programmable timing register. Reset loads every timing field with all ones, so the first transfers run at the slowest possible timing until software writes real values. A ready input from the memory may be enabled to stretch the strobe beyond its programmed count. When ready is disabled, only the fixed count applies. A new timing value is copied into the active timing when a request is accepted, so a register write never changes a transfer already in flight.

Top module: `amem_strobe_ctrl`

## Requirements
- R1: While reset is low, and right after it: memCeN, memOeN and memWeN are high, memDoutEn is low, reqReady is high, rspDone is low and rspData is zero. The ready input starts disabled.
- R2: With programmed counts S/T/H, an access holds chip-enable low with both enables high for S setup cycles, then T strobe cycles, then H hold cycles with both enables high. A field value of 0 behaves as 1.
- R3: memCeN stays low without a break from the first setup cycle to the last hold cycle. memAddr stays constant over that window. memCeN is high for at least one cycle between two accesses.
- R4: During strobe only memOeN goes low on a read (reqWrite=0) and only memWeN goes low on a write (reqWrite=1). The two are never low together.
- R5: On a write, memDoutEn is high from the first setup cycle through the last hold cycle, and memDout holds the request's write data for that whole window.
- R6: Read data on memDin is sampled at the clock edge that ends the last strobe cycle. It appears on rspData in the cycle after the hold phase, with a one-cycle rspDone pulse. It is kept until the next read completes.
- R7: A write ends with a one-cycle rspDone pulse in the cycle after hold and leaves rspData unchanged.
- R8: With ready enabled, the strobe phase ends only when the programmed count has run out and memRdy is high. Each cycle memRdy stays low after expiry adds one strobe cycle. An early high memRdy does not shorten the strobe.
- R9: With ready disabled, memRdy has no effect and the strobe lasts exactly T cycles.
- R10: A timing-register write (cfgWrite) takes effect from the next access accepted after the write's cycle. This holds whether the write falls inside an access or in the same cycle the access is accepted.
- R11: A request is accepted only in a cycle where reqReady is high. reqValid while an access is in progress starts nothing.
- R12: The first access after reset uses the all-ones timing. With the default widths this is 15 setup, 63 strobe and 15 hold cycles, which is 93 cycles of chip-enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| reqReady | output | 1 | Controller idle, request accepted this cycle if reqValid |
| rspData | output | DATA_W | Last read data |
| rspDone | output | 1 | One-cycle completion pulse |
| cfgWrite | input | 1 | Load timing register |
| cfgSetup | input | SETUP_W | Setup cycles |
| cfgStrobe | input | STROBE_W | Strobe cycles |
| cfgHold | input | HOLD_W | Hold cycles |
| cfgUseRdy | input | 1 | Enable ready stretching |
| memCeN | output | 1 | Chip-enable, active low |
| memOeN | output | 1 | Output-enable, active low |
| memWeN | output | 1 | Write-enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDout | output | DATA_W | Data toward memory |
| memDoutEn | output | 1 | Data bus drive enable |
| memDin | input | DATA_W | Data from memory |
| memRdy | input | 1 | Memory ready |

## Verification
Reads and writes are run at the reset timing, at a 2/8/2 setting and at an all-zero setting. These show whether phase counts are applied exactly and whether zero is treated as one. With ready enabled, memRdy is raised late, early and mid-strobe. The same late memRdy is then applied with ready disabled, which separates real stretching from a strobe that ignores its count. Timing writes land mid-access and in the accept cycle, and these expose a snapshot taken at the wrong edge. A reqValid pulse in mid-access checks that requests are refused while busy. A behavioural model compared every cycle catches any pin that moves one cycle early or late.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture request and snapshot timing
    logic capRead;   // sample memory read data
  } dpCtl_t;

endpackage

// File: rtl/amem_datapath.sv
module amem_datapath
  import amem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                cfgWrite,
  input  logic [SETUP_W-1:0]  cfgSetup,
  input  logic [STROBE_W-1:0] cfgStrobe,
  input  logic [HOLD_W-1:0]   cfgHold,
  input  logic                cfgUseRdy,
  input  logic [DATA_W-1:0]   memDin,
  output logic                curWrite,
  output logic [CNT_W-1:0]    setupLast,
  output logic [CNT_W-1:0]    strobeLast,
  output logic [CNT_W-1:0]    holdLast,
  output logic                useRdy,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDout,
  output logic [DATA_W-1:0]   rspData
);

  // programmed timing, all ones out of reset
  logic [SETUP_W-1:0]  progSetup;
  logic [STROBE_W-1:0] progStrobe;
  logic [HOLD_W-1:0]   progHold;
  logic                progUseRdy;

  // timing in force for the current access
  logic [SETUP_W-1:0]  actSetup;
  logic [STROBE_W-1:0] actStrobe;
  logic [HOLD_W-1:0]   actHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progSetup  <= '1;
      progStrobe <= '1;
      progHold   <= '1;
      progUseRdy <= 1'b0;
    end else if (cfgWrite) begin
      progSetup  <= cfgSetup;
      progStrobe <= cfgStrobe;
      progHold   <= cfgHold;
      progUseRdy <= cfgUseRdy;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSetup  <= '1;
      actStrobe <= '1;
      actHold   <= '1;
      useRdy    <= 1'b0;
      curWrite  <= 1'b0;
      memAddr   <= '0;
      memDout   <= '0;
    end else if (ctl.latchReq) begin
      actSetup  <= progSetup;
      actStrobe <= progStrobe;
      actHold   <= progHold;
      useRdy    <= progUseRdy;
      curWrite  <= reqWrite;
      memAddr   <= reqAddr;
      memDout   <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rspData <= '0;
    else if (ctl.capRead) rspData <= memDin;
  end

  // last counter index of each phase; a zero field means one cycle
  always_comb begin
    setupLast  = (actSetup  == '0) ? '0 : CNT_W'(actSetup)  - CNT_W'(1);
    strobeLast = (actStrobe == '0) ? '0 : CNT_W'(actStrobe) - CNT_W'(1);
    holdLast   = (actHold   == '0) ? '0 : CNT_W'(actHold)   - CNT_W'(1);
  end

endmodule

// File: rtl/amem_control.sv
module amem_control
  import amem_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             curWrite,
  input  logic             memRdy,
  input  logic [CNT_W-1:0] setupLast,
  input  logic [CNT_W-1:0] strobeLast,
  input  logic [CNT_W-1:0] holdLast,
  input  logic             useRdy,
  output dpCtl_t           ctl,
  output logic             reqReady,
  output logic             rspDone,
  output logic             memCeN,
  output logic             memOeN,
  output logic             memWeN,
  output logic             memDoutEn
);

  phase_e           phase, phaseNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             doneNx;

  always_comb begin
    phaseNx = phase;
    cntNx   = cnt;
    ctl     = '0;
    doneNx  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseNx      = PH_SETUP;
          cntNx        = '0;
          ctl.latchReq = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt >= setupLast) begin
          phaseNx = PH_STROBE;
          cntNx   = '0;
        end else begin
          cntNx = cnt + CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt >= strobeLast) begin
          // count spent: wait on ready only when enabled
          if (!useRdy || memRdy) begin
            phaseNx     = PH_HOLD;
            cntNx       = '0;
            ctl.capRead = !curWrite;
          end
        end else begin
          cntNx = cnt + CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt >= holdLast) begin
          phaseNx = PH_IDLE;
          cntNx   = '0;
          doneNx  = 1'b1;
        end else begin
          cntNx = cnt + CNT_W'(1);
        end
      end
      default: begin
        phaseNx = PH_IDLE;
        cntNx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      rspDone <= 1'b0;
    end else begin
      phase   <= phaseNx;
      cnt     <= cntNx;
      rspDone <= doneNx;
    end
  end

  always_comb begin
    reqReady  = (phase == PH_IDLE);
    memCeN    = (phase == PH_IDLE);
    memOeN    = !((phase == PH_STROBE) && !curWrite);
    memWeN    = !((phase == PH_STROBE) &&  curWrite);
    memDoutEn = curWrite && (phase != PH_IDLE);
  end

endmodule

// File: rtl/amem_strobe_ctrl.sv
module amem_strobe_ctrl
  import amem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                reqReady,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspDone,
  input  logic                cfgWrite,
  input  logic [SETUP_W-1:0]  cfgSetup,
  input  logic [STROBE_W-1:0] cfgStrobe,
  input  logic [HOLD_W-1:0]   cfgHold,
  input  logic                cfgUseRdy,
  output logic                memCeN,
  output logic                memOeN,
  output logic                memWeN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDout,
  output logic                memDoutEn,
  input  logic [DATA_W-1:0]   memDin,
  input  logic                memRdy
);

  localparam int SH_W  = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int CNT_W = (SH_W > STROBE_W) ? SH_W : STROBE_W;

  dpCtl_t           ctl;
  logic             curWrite;
  logic             useRdy;
  logic [CNT_W-1:0] setupLast, strobeLast, holdLast;

  amem_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_W(SETUP_W),
    .STROBE_W(STROBE_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgWrite(cfgWrite), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .cfgHold(cfgHold), .cfgUseRdy(cfgUseRdy), .memDin(memDin),
    .curWrite(curWrite), .setupLast(setupLast), .strobeLast(strobeLast),
    .holdLast(holdLast), .useRdy(useRdy),
    .memAddr(memAddr), .memDout(memDout), .rspData(rspData)
  );

  amem_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .curWrite(curWrite),
    .memRdy(memRdy), .setupLast(setupLast), .strobeLast(strobeLast),
    .holdLast(holdLast), .useRdy(useRdy), .ctl(ctl),
    .reqReady(reqReady), .rspDone(rspDone), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memDoutEn(memDoutEn)
  );

endmodule

// File: rtl/amem_checker.sv
module amem_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDoutEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              rspDone,
  input logic              reqReady
);

  p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    memOeN || memWeN);

  p_enable_in_ce_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !memCeN);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  p_we_drives_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDoutEn);

  p_dout_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && $past(memDoutEn)) |-> $stable(memDout));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (memCeN && reqReady));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_busy_refuse_r11: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !reqReady);

endmodule

bind amem_strobe_ctrl amem_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .memCeN(memCeN), .memOeN(memOeN),
  .memWeN(memWeN), .memDoutEn(memDoutEn), .memAddr(memAddr),
  .memDout(memDout), .rspDone(rspDone), .reqReady(reqReady)
);

// File: tb/tb_amem_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_amem_strobe_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic        reqReady, rspDone;
  logic [15:0] rspData;
  logic        cfgWrite = 1'b0, cfgUseRdy = 1'b0;
  logic [3:0]  cfgSetup = '0, cfgHold = '0;
  logic [5:0]  cfgStrobe = '0;
  logic        memCeN, memOeN, memWeN, memDoutEn;
  logic [15:0] memAddr, memDout, memDin;
  logic        memRdy = 1'b1;

  always #4 clk = ~clk;

  function automatic logic [15:0] rdFn(input logic [15:0] a);
    return {a[7:0], ~a[15:8]};
  endfunction
  assign memDin = rdFn(memAddr);

  amem_strobe_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspData(rspData), .rspDone(rspDone), .cfgWrite(cfgWrite),
    .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe), .cfgHold(cfgHold),
    .cfgUseRdy(cfgUseRdy), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin), .memRdy(memRdy)
  );

  int total = 0, bad = 0;
  bit cmpOn = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mState = 0, mCnt = 0;          // 0 idle 1 setup 2 strobe 3 hold
  int pSet = 15, pStr = 63, pHld = 15; bit pRdy = 0;
  int aSet = 15, aStr = 63, aHld = 15; bit aRdy = 0;
  bit mWrite = 0, mDone = 0;
  logic [15:0] mAddr = 0, mWdata = 0, mRdata = 0;

  function automatic int plen(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; pSet = 15; pStr = 63; pHld = 15; pRdy = 0;
      aSet = 15; aStr = 63; aHld = 15; aRdy = 0; mWrite = 0; mDone = 0;
      mAddr = 0; mWdata = 0; mRdata = 0;
    end else begin
      mDone = 0;
      case (mState)
        0: if (reqValid) begin
             mState = 1; mCnt = 1; mWrite = reqWrite; mAddr = reqAddr;
             mWdata = reqWdata; aSet = pSet; aStr = pStr; aHld = pHld; aRdy = pRdy;
           end
        1: if (mCnt >= plen(aSet)) begin mState = 2; mCnt = 1; end else mCnt++;
        2: if (mCnt >= plen(aStr)) begin
             if (!aRdy || memRdy) begin
               if (!mWrite) mRdata = rdFn(mAddr);
               mState = 3; mCnt = 1;
             end
           end else mCnt++;
        default: if (mCnt >= plen(aHld)) begin mState = 0; mDone = 1; end else mCnt++;
      endcase
      if (cfgWrite) begin
        pSet = cfgSetup; pStr = cfgStrobe; pHld = cfgHold; pRdy = cfgUseRdy;
      end
    end
  end

  // ---------------- per-cycle compare and length monitor ----------------
  int ceRun = 0, stbRun = 0, lastCe = 0, lastStb = 0, doneCnt = 0;
  int rdyAfter = 0;

  always @(negedge clk) begin
    if (cmpOn) begin
      check(memCeN === (mState == 0), "R3 memCeN", memCeN, mState == 0);
      check(memOeN === !(mState == 2 && !mWrite), "R2 memOeN", memOeN, !(mState == 2 && !mWrite));
      check(memWeN === !(mState == 2 && mWrite), "R4 memWeN", memWeN, !(mState == 2 && mWrite));
      check(memDoutEn === (mWrite && mState != 0), "R5 memDoutEn", memDoutEn, mWrite && mState != 0);
      if (mWrite && mState != 0) check(memDout === mWdata, "R5 memDout", memDout, mWdata);
      if (mState != 0) check(memAddr === mAddr, "R3 memAddr", memAddr, mAddr);
      check(reqReady === (mState == 0), "R11 reqReady", reqReady, mState == 0);
      check(rspDone === mDone, "R7 rspDone", rspDone, mDone);
      check(rspData === mRdata, "R6 rspData", rspData, mRdata);
    end
    if (!memCeN) ceRun++;
    if (!memOeN || !memWeN) stbRun++;
    if (rspDone) begin
      lastCe = ceRun; lastStb = stbRun; ceRun = 0; stbRun = 0; doneCnt++;
    end
    if (!memOeN || !memWeN) memRdy <= (stbRun >= rdyAfter);
    else                    memRdy <= (rdyAfter == 0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic startAccess(input bit w, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!rspDone);
    #1;
  endtask

  task automatic setCfg(input int s, input int t, input int h, input bit r);
    @(negedge clk);
    cfgWrite = 1; cfgSetup = 4'(s); cfgStrobe = 6'(t); cfgHold = 4'(h); cfgUseRdy = r;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d);
    startAccess(w, a, d);
    waitDone();
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  int base;
  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(memCeN === 1 && memOeN === 1 && memWeN === 1, "R1 enables high", {memCeN, memOeN, memWeN}, 7);
    check(memDoutEn === 0 && rspDone === 0, "R1 drive/done low", {memDoutEn, rspDone}, 0);
    check(reqReady === 1, "R1 reqReady", reqReady, 1);
    check(rspData === 0, "R1 rspData", rspData, 0);
    rstN = 1;
    @(negedge clk);
    cmpOn = 1;

    // R12 / R1: all-ones timing, ready disabled even though memRdy stays low
    rdyAfter = 1000;
    access(0, 16'h1234, 0);
    check(lastStb == 63, "R12 reset strobe", lastStb, 63);
    check(lastCe == 93, "R12 reset access", lastCe, 93);
    check(rspData === rdFn(16'h1234), "R6 read data", rspData, rdFn(16'h1234));
    rdyAfter = 0;

    // R2: 2/8/2 read and write
    setCfg(2, 8, 2, 0);
    access(0, 16'h00F0, 0);
    check(lastStb == 8 && lastCe == 12, "R2 read 2/8/2", lastCe, 12);
    access(1, 16'h0042, 16'hBEEF);
    check(lastStb == 8 && lastCe == 12, "R2 write 2/8/2", lastCe, 12);
    check(rspData === rdFn(16'h00F0), "R7 write keeps rspData", rspData, rdFn(16'h00F0));

    // R2: zero fields count as one
    setCfg(0, 0, 0, 0);
    access(0, 16'hA5A5, 0);
    check(lastStb == 1 && lastCe == 3, "R2 zero fields", lastCe, 3);

    // R8: ready stretching
    setCfg(2, 8, 2, 1);
    rdyAfter = 13;
    access(0, 16'h0777, 0);
    check(lastStb == 13 && lastCe == 17, "R8 late ready", lastStb, 13);
    rdyAfter = 3;
    access(0, 16'h0778, 0);
    check(lastStb == 8, "R8 early ready", lastStb, 8);
    rdyAfter = 11;
    access(1, 16'h0779, 16'h1357);
    check(lastStb == 11, "R8 write stretch", lastStb, 11);

    // R9: ready disabled ignores memRdy
    setCfg(2, 8, 2, 0);
    rdyAfter = 1000;
    access(0, 16'h0880, 0);
    check(lastStb == 8 && lastCe == 12, "R9 ready ignored", lastStb, 8);
    rdyAfter = 0;

    // R10: mid-access timing write
    startAccess(0, 16'h0990, 0);
    repeat (2) @(negedge clk);
    cfgWrite = 1; cfgSetup = 3; cfgStrobe = 4; cfgHold = 1; cfgUseRdy = 0;
    @(negedge clk); cfgWrite = 0;
    waitDone();
    check(lastStb == 8 && lastCe == 12, "R10 in-flight unchanged", lastCe, 12);
    access(0, 16'h0991, 0);
    check(lastStb == 4 && lastCe == 8, "R10 next access new", lastCe, 8);

    // R10: write in the accept cycle
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 16'h0AA0; reqWdata = 16'h2468;
    cfgWrite = 1; cfgSetup = 1; cfgStrobe = 2; cfgHold = 1; cfgUseRdy = 0;
    @(negedge clk);
    reqValid = 0; cfgWrite = 0;
    waitDone();
    check(lastStb == 4 && lastCe == 8, "R10 accept-cycle old timing", lastCe, 8);
    access(0, 16'h0AA1, 0);
    check(lastStb == 2 && lastCe == 4, "R10 following access", lastCe, 4);

    // R11: reqValid while busy is refused
    setCfg(2, 8, 2, 0);
    base = doneCnt;
    startAccess(0, 16'h0BB0, 0);
    repeat (4) @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 16'h0BB9; reqWdata = 16'hFFFF;
    @(negedge clk); reqValid = 0;
    waitDone();
    repeat (20) @(negedge clk);
    check(doneCnt - base == 1, "R11 busy request ignored", doneCnt - base, 1);
    check(memCeN === 1, "R11 no extra access", memCeN, 1);
    check(rspData === rdFn(16'h0BB0), "R6 busy read data", rspData, rdFn(16'h0BB0));

    finishRun();
  end

endmodule